// File: doc/BRIEF.md
# Receive Frame Port/DSCP Screener

This block assigns each received Ethernet frame to a receive queue. It watches the incoming byte stream and keeps two header values: the IPv4 DS/TC byte and the UDP destination port. It compares them at the same time against a small bank of screening rules. Each rule can require a DS/TC value, a UDP port value, or both. Each rule also names a target queue and carries a drop-on-match flag.

Rules are loaded through a one-word register write port. Frame bytes arrive with a valid strobe, a start-of-frame marker on the first byte and an end-of-frame marker on the last byte. The block produces one decision per frame. The decision is a queue number and a drop flag, together with a one-cycle valid pulse. It comes as soon as the last header byte it needs has arrived, or earlier if the frame ends first.

The block does not drop frames itself. The drop flag is only reported to the receive path.

Top module: `rx_port_screener`

## Requirements
- R1: After reset every rule is all zero and `dec_valid` is low. A frame that arrives before any rule is written is assigned queue 0 with the drop flag clear.
- R2: A rule word is written with `cfg_we` high. Its fields are: target queue in bits [3:0], DS/TC reference in bits [11:4], UDP port reference in bits [27:12], DS/TC compare enable in bit 28, port compare enable in bit 29, and drop flag in bit 30. `cfg_idx` selects the rule.
- R3: The DS/TC comparison uses frame byte 15. Byte 0 is the byte that carries start-of-frame.
- R4: The port comparison uses the 16-bit value formed from byte 36 as the high half and byte 37 as the low half.
- R5: A rule with both compares enabled hits only when both values agree. One disagreeing field defeats the rule.
- R6: A rule with neither compare enabled never hits, whatever its reference values are.
- R7: When several rules hit, the rule with the lowest index supplies the decision.
- R8: When no rule hits, the decision is queue 0 with the drop flag clear.
- R9: For a frame of at least 38 bytes, `dec_valid` is high for exactly one cycle: the cycle after the clock edge that accepts byte 37. Later bytes of the same frame cause no further decision.
- R10: For a frame that ends before byte 37, the decision appears the cycle after its last byte is accepted. Any enabled compare whose byte never arrived counts as a mismatch.
- R11: `dec_drop` equals bit 30 of the winning rule.
- R12: A write whose `cfg_idx` is not below the rule count changes no rule.
- R13: While `dec_valid` is low, `dec_queue` and `dec_drop` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_idx | input | IDX_W | Rule index of the write |
| cfg_wdata | input | 31 | Rule word |
| rx_valid | input | 1 | Frame byte present |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| dec_valid | output | 1 | Decision pulse |
| dec_queue | output | 4 | Selected queue |
| dec_drop | output | 1 | Drop flag of the winning rule |

## Verification
The bench builds the block with its defaults: four rules, a 3-bit rule index, and header positions 15 and 36. The 3-bit index lets the bench write to indices 4 to 7, which exist on the port but have no rule behind them. With four rules the bench can arrange hits on two low-numbered rules and on two high-numbered rules at once, so the priority order is tested from both ends. Frame lengths of 10, 20, 38 and 60 bytes cover the cases where neither header byte arrives, only the DS/TC byte arrives, the decision falls on the last byte, and bytes trail after the decision.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int RULE_W = 31;

  typedef struct packed {
    logic        drop;
    logic        port_en;
    logic        dscp_en;
    logic [15:0] port_ref;
    logic [7:0]  dscp_ref;
    logic [3:0]  queue;
  } rule_t;
endpackage

// File: rtl/scr_hdr_tap.sv
module scr_hdr_tap #(
  parameter int DSCP_POS = 15,
  parameter int PORT_POS = 36
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  output logic        eval,
  output logic        dscp_ok,
  output logic [7:0]  dscp_val,
  output logic        port_ok,
  output logic [15:0] port_val
);
  localparam int LAST_POS = PORT_POS + 1;
  localparam int CNT_W = $clog2(LAST_POS + 2);
  localparam logic [CNT_W-1:0] DSCP_AT = CNT_W'(DSCP_POS);
  localparam logic [CNT_W-1:0] PHI_AT  = CNT_W'(PORT_POS);
  localparam logic [CNT_W-1:0] LAST_AT = CNT_W'(LAST_POS);

  logic [CNT_W-1:0] cnt_q;
  logic             live_q;
  logic [7:0]       dscp_q;
  logic [7:0]       port_hi_q;
  logic             take;
  logic [CNT_W-1:0] pos;

  always_comb begin
    take     = rx_valid && (rx_sof || live_q);
    pos      = rx_sof ? '0 : cnt_q;
    eval     = take && ((pos == LAST_AT) || rx_eof);
    dscp_ok  = pos >= DSCP_AT;
    dscp_val = (pos == DSCP_AT) ? rx_data : dscp_q;
    port_ok  = pos == LAST_AT;
    port_val = {port_hi_q, rx_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      live_q    <= 1'b0;
      dscp_q    <= '0;
      port_hi_q <= '0;
    end else if (take) begin
      live_q <= !eval;
      cnt_q  <= eval ? '0 : pos + 1'b1;
      if (pos == DSCP_AT) dscp_q    <= rx_data;
      if (pos == PHI_AT)  port_hi_q <= rx_data;
    end
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_AT);
endmodule

// File: rtl/scr_rule_bank.sv
module scr_rule_bank
  import scr_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int IDX_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic [RULE_W-1:0]           cfg_wdata,
  output rule_t [NUM_RULES-1:0]       rules
);
  rule_t [NUM_RULES-1:0] rules_q;

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) rules_q[i] <= '0;
      else if (cfg_we && cfg_idx == IDX_W'(i)) rules_q[i] <= rule_t'(cfg_wdata);
    end
  end

  assign rules = rules_q;

  // R12
  oob_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_idx >= IDX_W'(NUM_RULES)) |=> $stable(rules_q));
endmodule

// File: rtl/scr_rule_match.sv
module scr_rule_match (
  input  logic        dscp_en,
  input  logic        port_en,
  input  logic [7:0]  dscp_ref,
  input  logic [15:0] port_ref,
  input  logic        dscp_ok,
  input  logic [7:0]  dscp_val,
  input  logic        port_ok,
  input  logic [15:0] port_val,
  output logic        hit
);
  logic dscp_bad, port_bad;

  always_comb begin
    dscp_bad = dscp_en && !(dscp_ok && dscp_val == dscp_ref);
    port_bad = port_en && !(port_ok && port_val == port_ref);
    hit      = (dscp_en || port_en) && !dscp_bad && !port_bad;
  end
endmodule

// File: rtl/scr_first_hit.sv
module scr_first_hit
  import scr_pkg::*;
#(
  parameter int NUM_RULES = 4
) (
  input  logic [NUM_RULES-1:0] hits,
  input  rule_t [NUM_RULES-1:0] rules,
  output logic                 any_hit,
  output logic [3:0]           queue,
  output logic                 drop
);
  logic [NUM_RULES-1:0] grant;
  logic [NUM_RULES:0]   seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_RULES; i++) begin : g_chain
    assign grant[i]  = hits[i] && !seen[i];
    assign seen[i+1] = seen[i] || hits[i];
  end

  always_comb begin
    queue = '0;
    drop  = 1'b0;
    for (int i = 0; i < NUM_RULES; i++) begin
      if (grant[i]) begin
        queue = queue | rules[i].queue;
        drop  = drop | rules[i].drop;
      end
    end
    any_hit = seen[NUM_RULES];
    // R7
    grant_onehot_chk: assert ($onehot0(grant));
  end
endmodule

// File: rtl/rx_port_screener.sv
module rx_port_screener
  import scr_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int IDX_W = 3,
  parameter int DSCP_POS = 15,
  parameter int PORT_POS = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [RULE_W-1:0] cfg_wdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  output logic              dec_valid,
  output logic [3:0]        dec_queue,
  output logic              dec_drop
);
  rule_t [NUM_RULES-1:0] rules;
  logic [NUM_RULES-1:0]  hits;
  logic        eval, dscp_ok, port_ok, any_hit, win_drop;
  logic [7:0]  dscp_val;
  logic [15:0] port_val;
  logic [3:0]  win_queue;

  scr_rule_bank #(.NUM_RULES(NUM_RULES), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .rules(rules));

  scr_hdr_tap #(.DSCP_POS(DSCP_POS), .PORT_POS(PORT_POS)) u_tap (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .eval(eval), .dscp_ok(dscp_ok),
    .dscp_val(dscp_val), .port_ok(port_ok), .port_val(port_val));

  for (genvar i = 0; i < NUM_RULES; i++) begin : g_rule
    scr_rule_match u_match (
      .dscp_en(rules[i].dscp_en), .port_en(rules[i].port_en),
      .dscp_ref(rules[i].dscp_ref), .port_ref(rules[i].port_ref),
      .dscp_ok(dscp_ok), .dscp_val(dscp_val),
      .port_ok(port_ok), .port_val(port_val), .hit(hits[i]));

    // R6
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
      hits[i] |-> (rules[i].dscp_en || rules[i].port_en));
  end

  scr_first_hit #(.NUM_RULES(NUM_RULES)) u_pick (
    .hits(hits), .rules(rules), .any_hit(any_hit),
    .queue(win_queue), .drop(win_drop));

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_queue <= '0;
      dec_drop  <= 1'b0;
    end else begin
      dec_valid <= eval;
      dec_queue <= (eval && any_hit) ? win_queue : '0;
      dec_drop  <= eval && any_hit && win_drop;
    end
  end

  // R13
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (dec_queue == '0 && !dec_drop));

  // R9
  pulse_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(rx_valid));
endmodule

// File: tb/test_rx_port_screener.sv
`timescale 1ns/1ps
module test_rx_port_screener;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [30:0] cfg_wdata = '0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        dec_valid, dec_drop;
  logic [3:0]  dec_queue;

  int checks = 0;
  int errors = 0;
  logic [30:0] model_rules [4];

  always #4 clk = ~clk;

  rx_port_screener i_rx_port_screener (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .dec_valid(dec_valid),
    .dec_queue(dec_queue), .dec_drop(dec_drop));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [30:0] mk(input bit drop, input bit pen, input bit den,
                                     input logic [15:0] port, input logic [7:0] ds,
                                     input logic [3:0] q);
    return {drop, pen, den, port, ds, q};
  endfunction

  function automatic logic [4:0] model(input int len, input logic [7:0] ds, input logic [15:0] pt);
    for (int i = 0; i < 4; i++) begin
      logic [30:0] r;
      bit den, pen, bad;
      r = model_rules[i];
      den = r[28];
      pen = r[29];
      bad = (den && !(len > 15 && ds == r[11:4])) || (pen && !(len > 37 && pt == r[27:12]));
      if ((den || pen) && !bad) return {r[30], r[3:0]};
    end
    return 5'd0;
  endfunction

  task automatic wr_rule(input int idx, input logic [30:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 4) model_rules[idx] = val;
  endtask

  task automatic clear_rules();
    for (int i = 0; i < 4; i++) wr_rule(i, '0);
  endtask

  function automatic logic [7:0] fbyte(input int i, input logic [7:0] ds, input logic [15:0] pt);
    if (i == 15) return ds;
    if (i == 36) return pt[15:8];
    if (i == 37) return pt[7:0];
    return 8'((i * 13 + 5) & 255);
  endfunction

  task automatic send_frame(input int len, input logic [7:0] ds, input logic [15:0] pt, input string req);
    logic [4:0] exp;
    int pulses, at;
    logic [3:0] q;
    logic d;
    int want_at;
    exp = model(len, ds, pt);
    want_at = (len > 38) ? 37 : len - 1;
    pulses = 0; at = -1; q = 0; d = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (dec_valid) begin pulses++; at = i - 1; q = dec_queue; d = dec_drop; end
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_data = fbyte(i, ds, pt);
    end
    @(negedge clk);
    if (dec_valid) begin pulses++; at = len - 1; q = dec_queue; d = dec_drop; end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (dec_valid) pulses++;
      check(dec_queue == 0 && !dec_drop, "R13 idle outputs", {27'd0, dec_drop, dec_queue}, 0);
    end
    check(pulses == 1, {req, " pulse count"}, pulses, 1);
    check(at == want_at, {req, " R9/R10 decision byte"}, at, want_at);
    check(q == exp[3:0], {req, " queue"}, q, exp[3:0]);
    check(d == exp[4], {req, " R11 drop"}, d, exp[4]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!dec_valid && dec_queue == 0 && !dec_drop, "R1 reset outputs", dec_valid, 0);
    send_frame(60, 8'h2e, 16'd53, "R1 R8 no rules");
  endtask

  task automatic t_dscp();
    clear_rules();
    wr_rule(0, mk(0, 0, 1, 16'h0, 8'hb8, 4'd5));
    send_frame(60, 8'hb8, 16'd1000, "R2 R3 dscp hit");
    send_frame(60, 8'hb9, 16'd1000, "R3 R8 dscp miss");
  endtask

  task automatic t_port();
    clear_rules();
    wr_rule(1, mk(1, 1, 0, 16'h12b5, 8'h00, 4'd9));
    send_frame(60, 8'h00, 16'h12b5, "R4 R11 port hit");
    send_frame(60, 8'h00, 16'hb512, "R4 byte order");
  endtask

  task automatic t_both();
    clear_rules();
    wr_rule(0, mk(0, 1, 1, 16'd4789, 8'h48, 4'd3));
    send_frame(60, 8'h48, 16'd4790, "R5 port disagrees");
    send_frame(60, 8'h49, 16'd4789, "R5 dscp disagrees");
    send_frame(60, 8'h48, 16'd4789, "R5 both agree");
  endtask

  task automatic t_noen();
    clear_rules();
    wr_rule(0, mk(1, 0, 0, 16'd80, 8'h10, 4'd7));
    send_frame(60, 8'h10, 16'd80, "R6 no enables");
  endtask

  task automatic t_prio();
    clear_rules();
    wr_rule(3, mk(0, 0, 1, 16'd0, 8'h20, 4'd12));
    wr_rule(2, mk(1, 1, 0, 16'd99, 8'h00, 4'd11));
    send_frame(60, 8'h20, 16'd99, "R7 rule2 over rule3");
    wr_rule(1, mk(0, 0, 1, 16'd0, 8'h20, 4'd6));
    wr_rule(0, mk(0, 1, 0, 16'd99, 8'h00, 4'd4));
    send_frame(60, 8'h20, 16'd99, "R7 rule0 over all");
  endtask

  task automatic t_short();
    clear_rules();
    wr_rule(0, mk(0, 1, 1, 16'd7, 8'h30, 4'd1));
    wr_rule(1, mk(1, 0, 1, 16'd0, 8'h30, 4'd2));
    send_frame(20, 8'h30, 16'd7, "R10 port missing");
    send_frame(10, 8'h30, 16'd7, "R10 dscp missing");
    send_frame(38, 8'h30, 16'd7, "R9 exact length");
  endtask

  task automatic t_oob();
    clear_rules();
    for (int i = 4; i < 8; i++) wr_rule(i, mk(1, 0, 1, 16'd0, 8'h55, 4'd15));
    send_frame(60, 8'h55, 16'd0, "R12 out of range write");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) model_rules[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_dscp();
    t_port();
    t_both();
    t_noen();
    t_prio();
    t_short();
    t_oob();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule